// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache

This block sits between the fetch port of a 32-bit core and a word-wide backing memory. It holds 256 lines of four 32-bit words. Bits [31:29] of each fetch address decide how the fetch is handled: it goes through the cache, becomes a single uncached read, or is refused as a bus error. On a hit the word comes from the line store with no cost. On a miss the block reads the whole aligned line from backing memory, one word per beat, then returns the word that was asked for. Every response carries the number of memory cycles the fetch consumed.

The request port also takes word stores. A store to the cache control address updates the instruction enable bit. When that bit changes, the block walks all lines, one per clock, and sets or clears the disabled flag in each tag. While the isolate input is high, any other store writes the word into the line store and leaves that line tagged invalid. Without isolate, such a store does not touch the cache. Each tag keeps the masked fetch address together with two flag bits. A tag with either flag set can never produce a hit.

Top module: `ifetch_cache`

## Requirements
- R1: After reset, `req_ready` stays low for exactly 256 cycles while the line store is cleared and every tag is marked invalid and disabled. The first fetch after that is a miss.
- R2: A fetch whose address bits [31:29] equal 1, 2, 3, 6 or 7 responds with `rsp_buserr`=1, data 0 and cost 0. It issues no memory read.
- R3: A fetch that hits responds exactly one cycle after it is accepted, with cost 0 and no memory read. `rsp_valid` is a single-cycle pulse.
- R4: A cached miss (bits [31:29] equal to 0 or 4) reads four words from memory in ascending order. The `mem_addr` of each beat is {3'b000, addr[28:4], beat[1:0], 2'b00}. The block holds `mem_addr` until that beat's `mem_rvalid` arrives. It returns the word selected by addr[3:2], with cost 4.
- R5: A fetch with bits [31:29]=5 makes one memory read at {3'b000, addr[28:2], 2'b00} and returns that word with cost 4. It allocates nothing, so a later cached fetch of the same line misses.
- R6: A hit needs the stored tag to equal addr[31:4] exactly. Addresses that share index bits [11:4] but differ in any upper bit, including bit 31 (segment 0 against segment 4), evict each other.
- R7: A store with `iso_store`=1 to any address other than the control address issues no memory read. It leaves that line invalid, so the next fetch of it misses and refills from memory.
- R8: A store with `iso_store`=0 to any address other than the control address has no effect: a line that was resident still hits.
- R9: A store to address 0xFFFE0130 whose bit 11 differs from the current enable holds `req_ready` low for exactly 256 cycles. After a change to 0, resident lines miss. After a change back to 1, lines that were disabled but not refilled hit again. A store that leaves bit 11 unchanged causes no stall.
- R10: `req_ready` is low whenever `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = word store, 0 = fetch |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Store data |
| iso_store | input | 1 | Isolate status: stores go to the cache array |
| req_ready | output | 1 | Request accepted on this edge when high |
| rsp_valid | output | 1 | Fetch response pulse |
| rsp_data | output | 32 | Fetched word |
| rsp_buserr | output | 1 | Fetch refused by segment |
| rsp_cost | output | 8 | Memory cycles charged to this fetch |
| mem_req | output | 1 | Backing memory read request, held until a beat returns |
| mem_addr | output | 32 | Backing memory byte address (word aligned) |
| mem_rvalid | input | 1 | Read word returned |
| mem_rdata | input | 32 | Returned word |

## Verification
Hits and bus errors respond at the second falling edge after the acceptance edge. The driver records the cycle count when it presents the request and queues the cycle in which it expects the response; the monitor compares that cycle with the one in which `rsp_valid` appears. Misses and uncached reads depend on the memory model's latency, so for those the bench checks only the response content and the logged memory addresses, after the queue has drained. Sweep and reset stalls are measured by counting falling edges with `req_ready` low, starting from the first falling edge after the accepting clock edge.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {SEG_CACHED, SEG_UNCACHED, SEG_BUSERR} seg_kind_t;
  typedef enum logic [2:0] {ST_IDLE, ST_LOOK, ST_FILL, ST_ONE, ST_SWEEP} ctl_state_t;

  function automatic seg_kind_t seg_classify(input logic [2:0] hi);
    case (hi)
      3'd0, 3'd4: seg_classify = SEG_CACHED;
      3'd5:       seg_classify = SEG_UNCACHED;
      default:    seg_classify = SEG_BUSERR;
    endcase
  endfunction
endpackage

// File: rtl/ifc_seg_decode.sv
module ifc_seg_decode
  import ifc_pkg::*;
(
  input  logic [2:0] addr_hi,
  output seg_kind_t  kind
);
  always_comb kind = seg_classify(addr_hi);
endmodule

// File: rtl/ifc_line_store.sv
module ifc_line_store #(
  parameter int LINES = 256,
  parameter int WORDS = 4,
  parameter int TAG_W = 28,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic                  clk,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [WORDS*32-1:0]   rd_line,
  output logic [TAG_W-1:0]      rd_tag,
  input  logic [WORDS-1:0]      data_we,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [31:0]           wr_data,
  input  logic                  tag_we,
  input  logic [TAG_W-1:0]      tag_wd
);
  logic [TAG_W-1:0] tag_mem [LINES];

  always_ff @(posedge clk) begin
    if (tag_we) tag_mem[wr_idx] <= tag_wd;
    rd_tag <= tag_mem[rd_idx];
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_bank
    logic [31:0] bank [LINES];
    always_ff @(posedge clk) begin
      if (data_we[w]) bank[wr_idx] <= wr_data;
      rd_line[w*32 +: 32] <= bank[rd_idx];
    end
  end
endmodule

// File: rtl/ifc_flag_array.sv
module ifc_flag_array #(
  parameter int LINES = 256,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_we,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             set_inv,
  input  logic             set_dis,
  input  logic             swp_we,
  input  logic [IDX_W-1:0] swp_idx,
  input  logic             swp_dis,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_inv,
  output logic             rd_dis
);
  logic [LINES-1:0] inv_q, dis_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_q <= '1;
      dis_q <= '1;
    end else if (set_we) begin
      inv_q[set_idx] <= set_inv;
      dis_q[set_idx] <= set_dis;
    end else if (swp_we) begin
      dis_q[swp_idx] <= swp_dis;
    end
  end

  assign rd_inv = inv_q[rd_idx];
  assign rd_dis = dis_q[rd_idx];

  // R9
  one_writer_chk: assert property (@(posedge clk) disable iff (rst) !(set_we && swp_we))
    else $error("line update and sweep in the same cycle");
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache
  import ifc_pkg::*;
#(
  parameter int          LINES       = 256,
  parameter int          LINE_BYTES  = 16,
  parameter int          FILL_COST   = 1,
  parameter int          SINGLE_COST = 4,
  parameter int          COST_W      = 8,
  parameter logic [31:0] CTRL_ADDR   = 32'hFFFE_0130,
  parameter int          EN_BIT      = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              iso_store,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              rsp_buserr,
  output logic [COST_W-1:0] rsp_cost,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata
);
  localparam int WORDS  = LINE_BYTES / 4;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = 32 - OFF_W;
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);
  localparam logic [IDX_W-1:0]  LAST_LINE = IDX_W'(LINES - 1);
  localparam logic [COST_W-1:0] MISS_COST = COST_W'(FILL_COST * WORDS);
  localparam logic [COST_W-1:0] ONE_COST  = COST_W'(SINGLE_COST);

  ctl_state_t        st;
  logic [31:2]       lk_addr;
  logic [WSEL_W-1:0] beat;
  logic [31:0]       hold_word;
  logic [IDX_W-1:0]  swp_idx;
  logic              swp_init, swp_dis, en_q;

  logic [IDX_W-1:0]  req_idx, lk_idx;
  logic [WSEL_W-1:0] req_wsel, lk_wsel;
  logic              is_ctrl, unused_lo;
  seg_kind_t         lk_kind;

  assign req_idx   = req_addr[OFF_W +: IDX_W];
  assign req_wsel  = req_addr[2 +: WSEL_W];
  assign lk_idx    = lk_addr[OFF_W +: IDX_W];
  assign lk_wsel   = lk_addr[2 +: WSEL_W];
  assign is_ctrl   = (req_addr == CTRL_ADDR);
  assign unused_lo = ^req_addr[1:0];

  // line store and flags
  logic [WORDS*32-1:0] rd_line;
  logic [TAG_W-1:0]    rd_tag, ls_tag_wd;
  logic [WORDS-1:0]    ls_data_we;
  logic [IDX_W-1:0]    ls_wr_idx, fl_set_idx;
  logic [31:0]         ls_wr_data;
  logic                ls_tag_we, fl_set_we, fl_set_inv, fl_set_dis, fl_swp_we;
  logic                rd_inv, rd_dis, hit;

  ifc_seg_decode u_seg (.addr_hi(lk_addr[31:29]), .kind(lk_kind));

  ifc_line_store #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rd_idx(req_idx), .rd_line(rd_line), .rd_tag(rd_tag),
    .data_we(ls_data_we), .wr_idx(ls_wr_idx), .wr_data(ls_wr_data),
    .tag_we(ls_tag_we), .tag_wd(ls_tag_wd)
  );

  ifc_flag_array #(.LINES(LINES)) u_flags (
    .clk(clk), .rst(rst),
    .set_we(fl_set_we), .set_idx(fl_set_idx), .set_inv(fl_set_inv), .set_dis(fl_set_dis),
    .swp_we(fl_swp_we), .swp_idx(swp_idx), .swp_dis(swp_dis),
    .rd_idx(lk_idx), .rd_inv(rd_inv), .rd_dis(rd_dis)
  );

  assign hit       = !rd_inv && !rd_dis && (rd_tag == lk_addr[31:OFF_W]);
  assign req_ready = (st == ST_IDLE);
  assign mem_req   = (st == ST_FILL) || (st == ST_ONE);

  always_comb begin
    if (st == ST_ONE) mem_addr = {3'b000, lk_addr[28:2], 2'b00};
    else              mem_addr = {3'b000, lk_addr[28:OFF_W], beat, 2'b00};
  end

  // write-port steering
  always_comb begin
    ls_data_we = '0;
    ls_wr_idx  = lk_idx;
    ls_wr_data = mem_rdata;
    ls_tag_we  = 1'b0;
    ls_tag_wd  = lk_addr[31:OFF_W];
    fl_set_we  = 1'b0;
    fl_set_idx = lk_idx;
    fl_set_inv = 1'b0;
    fl_set_dis = 1'b0;
    fl_swp_we  = 1'b0;
    case (st)
      ST_IDLE: if (req_valid && req_write && !is_ctrl && iso_store) begin
        ls_data_we[req_wsel] = 1'b1;
        ls_wr_idx  = req_idx;
        ls_wr_data = req_wdata;
        ls_tag_we  = 1'b1;
        ls_tag_wd  = req_addr[31:OFF_W];
        fl_set_we  = 1'b1;
        fl_set_idx = req_idx;
        fl_set_inv = 1'b1;
      end
      ST_FILL: if (mem_rvalid) begin
        ls_data_we[beat] = 1'b1;
        if (beat == LAST_BEAT) begin
          ls_tag_we = 1'b1;
          fl_set_we = 1'b1;
        end
      end
      ST_SWEEP: begin
        if (swp_init) begin
          ls_data_we = '1;
          ls_wr_idx  = swp_idx;
          ls_wr_data = '0;
          ls_tag_we  = 1'b1;
          ls_tag_wd  = '0;
        end else begin
          fl_swp_we = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // control sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_SWEEP;
      swp_init   <= 1'b1;
      swp_idx    <= '0;
      swp_dis    <= 1'b1;
      en_q       <= 1'b0;
      beat       <= '0;
      lk_addr    <= '0;
      hold_word  <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_buserr <= 1'b0;
      rsp_cost   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          if (req_write) begin
            if (is_ctrl) begin
              en_q <= req_wdata[EN_BIT];
              if (req_wdata[EN_BIT] != en_q) begin
                st       <= ST_SWEEP;
                swp_idx  <= '0;
                swp_init <= 1'b0;
                swp_dis  <= !req_wdata[EN_BIT];
              end
            end
          end else begin
            lk_addr <= req_addr[31:2];
            st      <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          case (lk_kind)
            SEG_CACHED: begin
              if (hit) begin
                rsp_valid  <= 1'b1;
                rsp_data   <= rd_line[lk_wsel*32 +: 32];
                rsp_buserr <= 1'b0;
                rsp_cost   <= '0;
                st         <= ST_IDLE;
              end else begin
                beat <= '0;
                st   <= ST_FILL;
              end
            end
            SEG_UNCACHED: st <= ST_ONE;
            default: begin
              rsp_valid  <= 1'b1;
              rsp_data   <= '0;
              rsp_buserr <= 1'b1;
              rsp_cost   <= '0;
              st         <= ST_IDLE;
            end
          endcase
        end
        ST_FILL: if (mem_rvalid) begin
          if (beat == lk_wsel) hold_word <= mem_rdata;
          beat <= beat + 1'b1;
          if (beat == LAST_BEAT) begin
            rsp_valid  <= 1'b1;
            rsp_data   <= (beat == lk_wsel) ? mem_rdata : hold_word;
            rsp_buserr <= 1'b0;
            rsp_cost   <= MISS_COST;
            st         <= ST_IDLE;
          end
        end
        ST_ONE: if (mem_rvalid) begin
          rsp_valid  <= 1'b1;
          rsp_data   <= mem_rdata;
          rsp_buserr <= 1'b0;
          rsp_cost   <= ONE_COST;
          st         <= ST_IDLE;
        end
        ST_SWEEP: begin
          swp_idx <= swp_idx + 1'b1;
          if (swp_idx == LAST_LINE) begin
            swp_init <= 1'b0;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1
  init_stall_chk: assert property (@(posedge clk) $fell(rst) |-> !req_ready)
    else $error("ready high right after reset");
  // R2
  buserr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_buserr |-> rsp_data == '0 && rsp_cost == '0)
    else $error("bus error response carries data or cost");
  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> !rsp_valid)
    else $error("back-to-back responses");
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr))
    else $error("memory address moved before its beat returned");
  // R10
  req_stall_chk: assert property (@(posedge clk) disable iff (rst) mem_req |-> !req_ready)
    else $error("ready high during a memory read");
endmodule

// File: tb/ifetch_cache_test.sv
module ifetch_cache_test;
  localparam int LINES = 256;
  localparam int LAT   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_write = 0, iso_store = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic        req_ready, rsp_valid, rsp_buserr, mem_req;
  logic [31:0] rsp_data, mem_addr;
  logic [7:0]  rsp_cost;
  logic        mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;

  ifetch_cache uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .iso_store(iso_store),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_buserr(rsp_buserr), .rsp_cost(rsp_cost), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int unsigned cyc = 0;
  int unsigned checks = 0, fails = 0, stall_bad = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h0001_0003) ^ 32'h5EED_C0DE;
  endfunction

  // backing memory model
  logic        pend = 0;
  int          cnt = 0;
  logic [31:0] cap = 0;
  logic [31:0] rd_log [$];
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_word(cap);
        pend       <= 1'b0;
      end else cnt <= cnt - 1;
    end else if (!rst && mem_req && !mem_rvalid) begin
      pend <= 1'b1;
      cap  <= mem_addr;
      cnt  <= LAT;
      rd_log.push_back(mem_addr);
    end
  end

  // scoreboard
  typedef struct packed {
    logic [31:0] data;
    logic        err;
    logic [7:0]  cost;
    logic [31:0] due;
  } exp_t;
  exp_t  exp_q [$];
  string tag_q [$];

  always @(negedge clk) begin
    if (!rst && mem_req && req_ready) stall_bad++;
    if (!rst && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R3 unexpected response: got data %h expected none", rsp_data);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_data !== e.data || rsp_buserr !== e.err || rsp_cost !== e.cost) begin
          fails++;
          $display("FAIL %s data/err/cost got %h/%0d/%0d expected %h/%0d/%0d",
                   t, rsp_data, rsp_buserr, rsp_cost, e.data, e.err, e.cost);
        end
        if (e.due != 0) begin
          checks++;
          if (cyc != e.due) begin
            fails++;
            $display("FAIL %s response cycle got %0d expected %0d", t, cyc, e.due);
          end
        end
      end
    end
  end

  task automatic check(input string t, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", t, got, exp);
    end
  endtask

  task automatic fetch(input logic [31:0] a, input logic [31:0] d, input logic err,
                       input logic [7:0] cost, input logic fast, input string t);
    exp_t e;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    e.data = d; e.err = err; e.cost = cost; e.due = fast ? cyc + 2 : 0;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic settle();
    while (!req_ready || exp_q.size() != 0 || pend) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // returns number of cycles ready stays low after the store
  task automatic store(input logic [31:0] a, input logic [31:0] d, input logic iso,
                       output int stall);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; iso_store = iso;
    @(negedge clk);
    req_valid = 0; req_write = 0; iso_store = 0;
    stall = 0;
    while (!req_ready) begin stall++; @(negedge clk); end
  endtask

  function automatic logic [31:0] ph(input logic [31:0] a);
    return {3'b000, a[28:2], 2'b00};
  endfunction

  initial begin : watchdog
    wait (cyc >= 100000);
    fails++;
    $display("FAIL R10 watchdog: cycle %0d expected below %0d", cyc, 100000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    int n, base;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 ready low after reset", {31'd0, req_ready}, 32'd0);
    n = 1;
    while (!req_ready) begin n++; @(negedge clk); end
    check("R1 init stall cycles", n, LINES);

    // R1 / R4: first fetch misses and refills the whole line in order
    rd_log.delete();
    fetch(32'h8000_0104, mem_word(32'h104), 0, 4, 0, "R4 miss word");
    settle();
    check("R4 refill beat count", rd_log.size(), 4);
    for (int i = 0; i < 4; i++) check("R4 refill beat address", rd_log[i], 32'h100 + 4*i);

    // R3: hits
    rd_log.delete();
    fetch(32'h8000_0108, mem_word(32'h108), 0, 0, 1, "R3 hit word2");
    fetch(32'h8000_010C, mem_word(32'h10C), 0, 0, 1, "R3 hit word3");
    fetch(32'h8000_0100, mem_word(32'h100), 0, 0, 1, "R3 hit word0");
    settle();
    check("R3 no memory read on hit", rd_log.size(), 0);

    // R6: same index, different upper bits
    fetch(32'h0000_0100, mem_word(32'h100), 0, 4, 0, "R6 alias seg0 misses");
    fetch(32'h8000_0104, mem_word(32'h104), 0, 4, 0, "R6 seg4 evicted");
    fetch(32'h8001_0104, mem_word(32'h10104), 0, 4, 0, "R6 upper bit differs");
    fetch(32'h8000_0100, mem_word(32'h100), 0, 4, 0, "R6 refill back");
    settle();

    // R5: uncached single read, no allocation
    rd_log.delete();
    fetch(32'hA000_0208, mem_word(32'h208), 0, 4, 0, "R5 uncached word");
    settle();
    check("R5 single read count", rd_log.size(), 1);
    check("R5 single read address", rd_log[0], ph(32'hA000_0208));
    fetch(32'h8000_0208, mem_word(32'h208), 0, 4, 0, "R5 no allocation");
    settle();

    // R2: bus error segments
    rd_log.delete();
    fetch(32'h2000_0000, 0, 1, 0, 1, "R2 segment 1");
    fetch(32'h4000_0104, 0, 1, 0, 1, "R2 segment 2");
    fetch(32'h6000_0010, 0, 1, 0, 1, "R2 segment 3");
    fetch(32'hC000_0200, 0, 1, 0, 1, "R2 segment 6");
    fetch(32'hE000_0100, 0, 1, 0, 1, "R2 segment 7");
    settle();
    check("R2 no memory read", rd_log.size(), 0);

    // R8: plain store ignored
    store(32'h8000_0200, 32'hDEAD_0001, 0, n);
    fetch(32'h8000_0200, mem_word(32'h200), 0, 0, 1, "R8 line still resident");
    settle();

    // R7: isolated store invalidates
    rd_log.delete();
    store(32'h8000_0204, 32'hDEAD_BEEF, 1, n);
    repeat (2) @(negedge clk);
    check("R7 isolated store reads no memory", rd_log.size(), 0);
    fetch(32'h8000_0204, mem_word(32'h204), 0, 4, 0, "R7 invalid line refills");
    settle();

    // R9: enable toggles and sweeps
    store(32'hFFFE_0130, 32'h0000_0800, 0, n);
    check("R9 enable sweep length", n, LINES);
    fetch(32'h8000_0108, mem_word(32'h108), 0, 0, 1, "R9 clean line hits when enabled");
    settle();
    store(32'hFFFE_0130, 32'h0000_0800, 0, n);
    check("R9 unchanged enable no stall", n, 0);
    store(32'hFFFE_0130, 32'h0000_0000, 0, n);
    check("R9 disable sweep length", n, LINES);
    fetch(32'h8000_0200, mem_word(32'h200), 0, 4, 0, "R9 disabled line misses");
    settle();
    store(32'hFFFE_0130, 32'h0000_0800, 0, n);
    check("R9 re-enable sweep length", n, LINES);
    fetch(32'h8000_0104, mem_word(32'h104), 0, 0, 1, "R9 re-enabled line hits");
    settle();

    base = stall_bad;
    check("R10 ready low during memory reads", base, 0);
    check("R3 scoreboard drained", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule